// File: doc/BRIEF.md
# Multi-Cycle Control Sequencer for a Single-Bus 16-bit Datapath

This block is the control unit of a small 16-bit processor whose datapath has one shared bus. Each clock cycle it emits a control word: which single source drives the bus (program counter, memory data register, ALU result or address adder), which registers capture a value (address register, memory data register, instruction register, register file, condition codes, program counter), how the address adder, ALU and operand muxes are set, and whether memory is enabled for a read or a write.

Every instruction starts with a three-state fetch followed by one decode state. The sequencer then follows an execute path picked from the 4-bit opcode field of the instruction register. It covers register-to-register arithmetic and logic, effective-address load, register jump, direct, base-relative and indirect loads and stores. Each memory state waits for a ready flag from memory. The indirect forms go to memory twice. The register file, ALU, memory and the muxes themselves live in the datapath outside this block.

Top module: `bus_seq_ctrl`

## Requirements
- R1: After reset the first control word is the fetch start: gate_pc, ld_mar and ld_pc high with pc_sel=0 (increment), every other gate, load and mem_en low.
- R2: Fetch takes three states: PC to MAR with PC increment, memory read into MDR (mdr_sel=1 selects memory), then MDR onto the bus into the IR. A decode state with no loads follows. With no memory wait, ADD, AND, NOT, LEA and JMP take 5 cycles in total.
- R3: Opcode 0001 (ADD), 0101 (AND) and 1001 (NOT) take one execute state. It has sr1_sel=0 (field IR[8:6]), alu_op 0=add, 1=and, 2=not, gate_alu, ld_reg and ld_cc. The destination is IR[11:9] and the second operand is IR[2:0].
- R4: Opcode 1110 (LEA) puts PC plus sign-extended IR[8:0] on the bus into the destination register. It uses addr1_sel=0 (PC), addr2_sel=2 (9-bit offset) and gate_addr, and never asserts ld_cc.
- R5: Opcode 1100 (JMP) loads the PC with the register named by IR[8:6]. It uses addr1_sel=1 (first source), addr2_sel=0 (zero) and pc_sel=1 (adder).
- R6: Opcode 0010 (LD, PC plus 9-bit offset) and 0110 (LDR, register IR[8:6] plus sign-extended IR[5:0], addr2_sel=1) put the address in the MAR, read memory into the MDR, then gate the MDR into the destination with ld_cc. This is 7 cycles with no wait.
- R7: Opcode 0011 (ST) and 0111 (STR) take three states: address to MAR, register IR[11:9] (sr1_sel=1) through the ALU pass-through (alu_op=3) into the MDR with mdr_sel=0, then a memory write. This is 7 cycles with no wait.
- R8: Opcode 1010 (LDI) takes five execute states: address to MAR, read, MDR to MAR, second read, MDR to destination with ld_cc. This is 9 cycles with no wait.
- R9: Opcode 1011 (STI) takes five execute states: address to MAR, read pointer, MDR to MAR, source through the ALU into the MDR, memory write. This is 9 cycles with no wait.
- R10: Every state with mem_en held stays, unchanged, until mem_rdy is high. A read loads the MDR only in the ready cycle. Each cycle of delay on mem_rdy adds exactly one cycle per memory access.
- R11: Any other opcode goes from decode straight back to fetch and loads nothing (4 cycles with no wait).
- R12: At most one of gate_pc, gate_mdr, gate_alu, gate_addr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_op | input | 4 | Opcode field IR[15:12] of the instruction register |
| mem_rdy | input | 1 | Memory has completed the current access |
| gate_pc | output | 1 | PC drives the bus |
| gate_mdr | output | 1 | MDR drives the bus |
| gate_alu | output | 1 | ALU result drives the bus |
| gate_addr | output | 1 | Address adder drives the bus |
| ld_mar | output | 1 | MAR captures the bus |
| ld_mdr | output | 1 | MDR captures its mux output |
| ld_ir | output | 1 | IR captures the bus |
| ld_reg | output | 1 | Register IR[11:9] captures the bus |
| ld_cc | output | 1 | Condition codes update from the bus |
| ld_pc | output | 1 | PC captures its mux output |
| sr1_sel | output | 1 | First source field: 0=IR[8:6], 1=IR[11:9] |
| addr1_sel | output | 1 | Adder base: 0=PC, 1=first source |
| addr2_sel | output | 2 | Adder offset: 0=zero, 1=sext IR[5:0], 2=sext IR[8:0] |
| pc_sel | output | 1 | PC source: 0=PC+1, 1=adder |
| mdr_sel | output | 1 | MDR source: 0=bus, 1=memory |
| alu_op | output | 2 | 0=add, 1=and, 2=not, 3=pass first source |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Access is a write |

## Verification
The bench runs one program through a behavioural datapath and memory twice: once with memory answering at once, and once with two wait cycles per access. Comparing instruction lengths between the two runs separates a sequencer that waits on mem_rdy from one that ignores it or waits more than once per access. The program covers all eleven opcodes plus two unused ones. Register values chosen to give positive, zero and negative results expose wrong ALU selects and stray or missing condition-code loads. Direct, base-relative and indirect accesses to distinct addresses show whether the right offset, base field and number of memory trips were used.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LEA = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_LD  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ST  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_LDI = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_STI = 4'b1011;

    typedef enum logic [3:0] {
        S_FETCH_PC, S_FETCH_RD, S_FETCH_IR, S_DECODE,
        S_ALU, S_LEA, S_JMP,
        S_ADDR, S_RD_1, S_PTR, S_RD_2, S_WBACK, S_SRC, S_WRITE
    } seq_state_e;

    typedef enum logic [2:0] {
        C_ALU, C_LEA, C_JMP, C_LOAD, C_STORE, C_LOAD_IND, C_STORE_IND, C_NONE
    } op_class_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0, ALU_AND = 2'd1, ALU_NOT = 2'd2, ALU_PASS = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        OFS_ZERO = 2'd0, OFS_SHORT = 2'd1, OFS_LONG = 2'd2
    } ofs_sel_e;

    typedef struct packed {
        op_class_e cls;
        logic      base_rel;
        alu_op_e   alu;
    } op_info_t;

    typedef struct packed {
        logic     gate_pc;
        logic     gate_mdr;
        logic     gate_alu;
        logic     gate_addr;
        logic     ld_mar;
        logic     ld_mdr;
        logic     ld_ir;
        logic     ld_reg;
        logic     ld_cc;
        logic     ld_pc;
        logic     sr1_sel;
        logic     addr1_sel;
        ofs_sel_e addr2_sel;
        logic     pc_sel;
        logic     mdr_sel;
        alu_op_e  alu;
        logic     mem_en;
        logic     mem_we;
    } ctrl_word_t;

    typedef struct packed {
        seq_state_e st;
    } seq_reg_t;

endpackage

// File: rtl/bus_seq_opdec.sv
module bus_seq_opdec
    import bus_seq_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output op_info_t         info
);
    always_comb begin
        info.cls      = C_NONE;
        info.base_rel = 1'b0;
        info.alu      = ALU_PASS;
        case (opc)
            OPC_ADD: begin info.cls = C_ALU; info.alu = ALU_ADD; end
            OPC_AND: begin info.cls = C_ALU; info.alu = ALU_AND; end
            OPC_NOT: begin info.cls = C_ALU; info.alu = ALU_NOT; end
            OPC_LEA: info.cls = C_LEA;
            OPC_JMP: info.cls = C_JMP;
            OPC_LD:  info.cls = C_LOAD;
            OPC_LDR: begin info.cls = C_LOAD; info.base_rel = 1'b1; end
            OPC_ST:  info.cls = C_STORE;
            OPC_STR: begin info.cls = C_STORE; info.base_rel = 1'b1; end
            OPC_LDI: info.cls = C_LOAD_IND;
            OPC_STI: info.cls = C_STORE_IND;
            default: info.cls = C_NONE;
        endcase
    end
endmodule

// File: rtl/bus_seq_next.sv
module bus_seq_next
    import bus_seq_pkg::*;
(
    input  seq_reg_t  cur_q,
    input  op_info_t  info,
    input  logic      mem_rdy,
    output seq_reg_t  nxt_d
);
    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            S_FETCH_PC: nxt_d.st = S_FETCH_RD;
            S_FETCH_RD: if (mem_rdy) nxt_d.st = S_FETCH_IR;
            S_FETCH_IR: nxt_d.st = S_DECODE;
            S_DECODE: begin
                case (info.cls)
                    C_ALU:   nxt_d.st = S_ALU;
                    C_LEA:   nxt_d.st = S_LEA;
                    C_JMP:   nxt_d.st = S_JMP;
                    C_NONE:  nxt_d.st = S_FETCH_PC;
                    default: nxt_d.st = S_ADDR;
                endcase
            end
            S_ADDR:  nxt_d.st = (info.cls == C_STORE) ? S_SRC : S_RD_1;
            S_RD_1: begin
                if (mem_rdy) begin
                    nxt_d.st = (info.cls == C_LOAD) ? S_WBACK : S_PTR;
                end
            end
            S_PTR:   nxt_d.st = (info.cls == C_LOAD_IND) ? S_RD_2 : S_SRC;
            S_RD_2:  if (mem_rdy) nxt_d.st = S_WBACK;
            S_SRC:   nxt_d.st = S_WRITE;
            S_WRITE: if (mem_rdy) nxt_d.st = S_FETCH_PC;
            default: nxt_d.st = S_FETCH_PC;
        endcase
    end
endmodule

// File: rtl/bus_seq_ctrl_out.sv
module bus_seq_ctrl_out
    import bus_seq_pkg::*;
(
    input  seq_state_e st,
    input  op_info_t   info,
    input  logic       mem_rdy,
    output ctrl_word_t cw
);
    always_comb begin
        cw = '0;
        case (st)
            S_FETCH_PC: begin
                cw.gate_pc = 1'b1;
                cw.ld_mar  = 1'b1;
                cw.ld_pc   = 1'b1;
            end
            S_FETCH_RD, S_RD_1, S_RD_2: begin
                cw.mem_en  = 1'b1;
                cw.mdr_sel = 1'b1;
                cw.ld_mdr  = mem_rdy;
            end
            S_FETCH_IR: begin
                cw.gate_mdr = 1'b1;
                cw.ld_ir    = 1'b1;
            end
            S_ALU: begin
                cw.alu      = info.alu;
                cw.gate_alu = 1'b1;
                cw.ld_reg   = 1'b1;
                cw.ld_cc    = 1'b1;
            end
            S_LEA: begin
                cw.addr2_sel = OFS_LONG;
                cw.gate_addr = 1'b1;
                cw.ld_reg    = 1'b1;
            end
            S_JMP: begin
                cw.addr1_sel = 1'b1;
                cw.addr2_sel = OFS_ZERO;
                cw.pc_sel    = 1'b1;
                cw.ld_pc     = 1'b1;
            end
            S_ADDR: begin
                cw.addr1_sel = info.base_rel;
                cw.addr2_sel = info.base_rel ? OFS_SHORT : OFS_LONG;
                cw.gate_addr = 1'b1;
                cw.ld_mar    = 1'b1;
            end
            S_PTR: begin
                cw.gate_mdr = 1'b1;
                cw.ld_mar   = 1'b1;
            end
            S_WBACK: begin
                cw.gate_mdr = 1'b1;
                cw.ld_reg   = 1'b1;
                cw.ld_cc    = 1'b1;
            end
            S_SRC: begin
                cw.sr1_sel  = 1'b1;
                cw.alu      = ALU_PASS;
                cw.gate_alu = 1'b1;
                cw.ld_mdr   = 1'b1;
            end
            S_WRITE: begin
                cw.mem_en = 1'b1;
                cw.mem_we = 1'b1;
            end
            default: cw = '0;
        endcase
    end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
    import bus_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] ir_op,
    input  logic             mem_rdy,
    output logic             gate_pc,
    output logic             gate_mdr,
    output logic             gate_alu,
    output logic             gate_addr,
    output logic             ld_mar,
    output logic             ld_mdr,
    output logic             ld_ir,
    output logic             ld_reg,
    output logic             ld_cc,
    output logic             ld_pc,
    output logic             sr1_sel,
    output logic             addr1_sel,
    output logic [1:0]       addr2_sel,
    output logic             pc_sel,
    output logic             mdr_sel,
    output logic [1:0]       alu_op,
    output logic             mem_en,
    output logic             mem_we
);
    op_info_t   info;
    seq_reg_t   seq_d;
    seq_reg_t   seq_q;
    ctrl_word_t cw;

    bus_seq_opdec u_opdec (
        .opc  (ir_op),
        .info (info)
    );

    bus_seq_next u_next (
        .cur_q   (seq_q),
        .info    (info),
        .mem_rdy (mem_rdy),
        .nxt_d   (seq_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= S_FETCH_PC;
        end else begin
            seq_q <= seq_d;
        end
    end

    bus_seq_ctrl_out u_out (
        .st      (seq_q.st),
        .info    (info),
        .mem_rdy (mem_rdy),
        .cw      (cw)
    );

    assign gate_pc   = cw.gate_pc;
    assign gate_mdr  = cw.gate_mdr;
    assign gate_alu  = cw.gate_alu;
    assign gate_addr = cw.gate_addr;
    assign ld_mar    = cw.ld_mar;
    assign ld_mdr    = cw.ld_mdr;
    assign ld_ir     = cw.ld_ir;
    assign ld_reg    = cw.ld_reg;
    assign ld_cc     = cw.ld_cc;
    assign ld_pc     = cw.ld_pc;
    assign sr1_sel   = cw.sr1_sel;
    assign addr1_sel = cw.addr1_sel;
    assign addr2_sel = cw.addr2_sel;
    assign pc_sel    = cw.pc_sel;
    assign mdr_sel   = cw.mdr_sel;
    assign alu_op    = cw.alu;
    assign mem_en    = cw.mem_en;
    assign mem_we    = cw.mem_we;
endmodule

// File: rtl/bus_seq_checker.sv
module bus_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic mem_rdy,
    input logic gate_pc,
    input logic gate_mdr,
    input logic gate_alu,
    input logic gate_addr,
    input logic ld_mar,
    input logic ld_mdr,
    input logic ld_ir,
    input logic ld_reg,
    input logic ld_cc,
    input logic mdr_sel,
    input logic mem_en,
    input logic mem_we
);
    AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate_pc, gate_mdr, gate_alu, gate_addr})); // R12

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && !mem_rdy |=> mem_en && $stable(mem_we)); // R10

    AST_MDR_READ_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mdr && mdr_sel |-> mem_en && mem_rdy && !mem_we); // R10

    AST_IR_FROM_MDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |-> gate_mdr && !ld_reg && !ld_mar); // R2

    AST_PC_TO_MAR: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pc |-> ld_mar && !mem_en); // R1

    AST_ADDR_NO_CC: assert property (@(posedge clk) disable iff (!rst_n)
        gate_addr |-> !ld_cc); // R4

    AST_WBACK_CC: assert property (@(posedge clk) disable iff (!rst_n)
        gate_mdr && ld_reg |-> ld_cc); // R6

    AST_WRITE_AFTER_MDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(ld_mdr) && !$past(mdr_sel)); // R7
endmodule

bind bus_seq_ctrl bus_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdy   (mem_rdy),
    .gate_pc   (gate_pc),
    .gate_mdr  (gate_mdr),
    .gate_alu  (gate_alu),
    .gate_addr (gate_addr),
    .ld_mar    (ld_mar),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .ld_reg    (ld_reg),
    .ld_cc     (ld_cc),
    .mdr_sel   (mdr_sel),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
);

// File: tb/bus_seq_ctrl_bench.sv
`timescale 1ns/1ps
module bus_seq_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_rdy = 1'b0;
    logic gate_pc, gate_mdr, gate_alu, gate_addr;
    logic ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc;
    logic sr1_sel, addr1_sel, pc_sel, mdr_sel, mem_en, mem_we;
    logic [1:0] addr2_sel, alu_op;

    int n_chk = 0;
    int n_fail = 0;
    int gate_clash = 0;
    int mem_lat = 0;
    int wait_cnt = 0;

    // behavioural datapath
    logic [15:0] pc, mar, mdr, ir_q;
    logic [15:0] regs [8];
    logic [15:0] mem [256];
    logic [2:0]  cc;
    logic [15:0] sr1v, sr2v, aluv, ofs, adder, bus;

    always #4 clk = ~clk;

    bus_seq_ctrl u_bus_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ir_op(ir_q[15:12]), .mem_rdy(mem_rdy),
        .gate_pc(gate_pc), .gate_mdr(gate_mdr), .gate_alu(gate_alu), .gate_addr(gate_addr),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_reg(ld_reg), .ld_cc(ld_cc),
        .ld_pc(ld_pc), .sr1_sel(sr1_sel), .addr1_sel(addr1_sel), .addr2_sel(addr2_sel),
        .pc_sel(pc_sel), .mdr_sel(mdr_sel), .alu_op(alu_op), .mem_en(mem_en), .mem_we(mem_we)
    );

    function automatic logic [15:0] init_word(input logic [7:0] a);
        case (a)
            8'd0:  return 16'h1842; // ADD r4,r1,r2
            8'd1:  return 16'h5A43; // AND r5,r1,r3
            8'd2:  return 16'h9C7F; // NOT r6,r1
            8'd3:  return 16'hEFFD; // LEA r7,-3
            8'd4:  return 16'h200A; // LD r0,+10
            8'd5:  return 16'h68F0; // LDR r4,r3,-16
            8'd6:  return 16'h3214; // ST r1,+20
            8'd7:  return 16'h74C5; // STR r2,r3,+5
            8'd8:  return 16'hAA06; // LDI r5,+6
            8'd9:  return 16'hBC07; // STI r6,+7
            8'd10: return 16'h0000; // unused opcode
            8'd11: return 16'hF025; // unused opcode
            8'd12: return 16'hC1C0; // JMP r7
            8'd15: return 16'h1234;
            8'd17: return 16'h0050;
            8'h34: return 16'h0042;
            8'hE0: return 16'h8001;
            default: return 16'h0000;
        endcase
    endfunction

    always_comb begin
        sr1v = regs[sr1_sel ? ir_q[11:9] : ir_q[8:6]];
        sr2v = regs[ir_q[2:0]];
        case (alu_op)
            2'd0: aluv = sr1v + sr2v;
            2'd1: aluv = sr1v & sr2v;
            2'd2: aluv = ~sr1v;
            default: aluv = sr1v;
        endcase
        case (addr2_sel)
            2'd1: ofs = {{10{ir_q[5]}}, ir_q[5:0]};
            2'd2: ofs = {{7{ir_q[8]}}, ir_q[8:0]};
            default: ofs = 16'h0;
        endcase
        adder = (addr1_sel ? sr1v : pc) + ofs;
        bus = gate_pc ? pc : gate_mdr ? mdr : gate_alu ? aluv : gate_addr ? adder : 16'h0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= 16'h0; mar <= 16'h0; mdr <= 16'h0; ir_q <= 16'h0; cc <= 3'b010;
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i[7:0]);
            for (int i = 0; i < 8; i++) regs[i] <= 16'h0;
            regs[1] <= 16'd5; regs[2] <= 16'd3; regs[3] <= 16'h00F0;
        end else begin
            if (ld_mar) mar <= bus;
            if (ld_mdr) mdr <= mdr_sel ? mem[mar[7:0]] : bus;
            if (mem_en && mem_we && mem_rdy) mem[mar[7:0]] <= mdr;
            if (ld_ir) ir_q <= bus;
            if (ld_reg) regs[ir_q[11:9]] <= bus;
            if (ld_cc) cc <= bus[15] ? 3'b100 : (bus == 16'h0) ? 3'b010 : 3'b001;
            if (ld_pc) pc <= pc_sel ? adder : pc + 16'd1;
        end
    end

    // memory ready model and bus-gate monitor
    always @(negedge clk) begin
        if (!rst_n || !mem_en) begin
            mem_rdy = 1'b0;
            wait_cnt = 0;
        end else begin
            mem_rdy = (wait_cnt == mem_lat);
            wait_cnt = wait_cnt + 1;
        end
        if (rst_n && ($countones({gate_pc, gate_mdr, gate_alu, gate_addr}) > 1))
            gate_clash = gate_clash + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_one(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!(gate_pc && ld_mar) && cyc < 200);
    endtask

    task automatic start_run(input int lat);
        @(negedge clk);
        rst_n = 1'b0;
        mem_lat = lat;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_reset_word();
        chk("R1 fetch gates/loads", {gate_pc, ld_mar, ld_pc, pc_sel}, 4'b1110);
        chk("R1 others idle", {gate_mdr, gate_alu, gate_addr, ld_mdr, ld_ir, ld_reg, ld_cc, mem_en, mem_we}, 9'h0);
    endtask

    task automatic test_program(input int lat);
        int c;
        run_one(c); chk("R2 R3 ADD cycles", c, 5 + lat);
        chk("R3 ADD result", regs[4], 16'd8); chk("R3 ADD cc", cc, 3'b001);
        run_one(c); chk("R3 AND result", regs[5], 16'd0); chk("R3 AND cc", cc, 3'b010);
        run_one(c); chk("R3 NOT result", regs[6], 16'hFFFA); chk("R3 NOT cc", cc, 3'b100);
        run_one(c); chk("R4 LEA cycles", c, 5 + lat);
        chk("R4 LEA result", regs[7], 16'd1); chk("R4 LEA keeps cc", cc, 3'b100);
        run_one(c); chk("R6 LD cycles", c, 7 + 2 * lat);
        chk("R6 LD result", regs[0], 16'h1234); chk("R6 LD cc", cc, 3'b001);
        run_one(c); chk("R6 LDR cycles", c, 7 + 2 * lat);
        chk("R6 LDR result", regs[4], 16'h8001); chk("R6 LDR cc", cc, 3'b100);
        run_one(c); chk("R7 ST cycles", c, 7 + 2 * lat); chk("R7 ST mem", mem[27], 16'd5);
        run_one(c); chk("R7 STR cycles", c, 7 + 2 * lat); chk("R7 STR mem", mem[8'hF5], 16'd3);
        run_one(c); chk("R8 LDI cycles", c, 9 + 3 * lat);
        chk("R8 LDI result", regs[5], 16'h0042); chk("R8 LDI cc", cc, 3'b001);
        run_one(c); chk("R9 STI cycles", c, 9 + 3 * lat);
        chk("R9 STI mem", mem[8'h50], 16'hFFFA); chk("R9 STI pointer kept", mem[17], 16'h0050);
        run_one(c); chk("R11 opcode 0000 cycles", c, 4 + lat);
        run_one(c); chk("R11 opcode 1111 cycles", c, 4 + lat);
        chk("R11 no register change", {regs[0], regs[5]}, {16'h1234, 16'h0042});
        chk("R11 no cc change", cc, 3'b001); chk("R11 pc advanced", pc, 16'd12);
        run_one(c); chk("R5 JMP cycles", c, 5 + lat); chk("R5 JMP target", pc, 16'd1);
    endtask

    initial begin
        start_run(0);
        test_reset_word();
        test_program(0);
        start_run(2);
        test_reset_word();
        test_program(2); // R10: each access stretched by the wait cycles
        chk("R12 single bus driver", gate_clash, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule